// File: doc/BRIEF.md
# Sized compare and condition-code unit

This block compares two operands by subtracting a source from a destination and records the outcome as a set of condition flags. The difference itself goes nowhere: no operand is written back, and the only lasting effect of a compare is the new flag state. A surrounding execution pipeline presents the two operands, the operation width and a mode bit, and pulses a valid strobe. On the next clock edge the flag register holds negative, zero, overflow and borrow for that compare.

The unit has two compare modes. The plain compare works at byte, word or long width and looks only at the low bits of that width. The address compare is meant for 32-bit address registers. In this mode a word source is sign-extended to 32 bits and the full destination is always used. An extend flag sits in the register next to the four result flags, and no compare ever changes it. An illegal width code is flagged on an error output and leaves the register alone.

Top module: `cmp_flag_unit`

## Requirements
- R1: With size code 10 (long) in plain mode, N, Z, V and C describe the 32-bit difference dst_i minus src_i.
- R2: With size code 00 (byte) in plain mode, the flags depend only on bits 7:0 of both operands. N is bit 7 of the 8-bit difference and Z means the low bytes are equal.
- R3: With size code 01 (word) in plain mode, the flags depend only on bits 15:0 of both operands. N is bit 15 of the 16-bit difference.
- R4: V is set when the two operands have different signs at the selected width and the sign of the result differs from the sign of the destination. Otherwise V is clear.
- R5: C is set when the source, read as unsigned at the selected width, is greater than the destination. Otherwise C is clear.
- R6: In address mode with size code 01, bits 15:0 of the source are sign-extended to 32 bits and compared with all 32 bits of the destination.
- R7: In address mode with size code 10, the compare uses all 32 bits, exactly as a long compare does.
- R8: ccr_o is laid out as {X, N, Z, V, C} on bits 4 to 0. Bit 4 (X) is never changed by a compare.
- R9: ccr_o loads only on a clock edge where valid_i is high, and shows that compare's flags from the following cycle. While valid_i is low it holds its value.
- R10: Size code 11 in any mode, and size code 00 in address mode, are illegal. For one cycle after such a valid compare err_o is high, and ccr_o does not change. err_o is low at all other times.
- R11: Synchronous active-high reset clears ccr_o and err_o to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Compare strobe |
| dst_i | input | 32 | Destination operand (minuend) |
| src_i | input | 32 | Source operand (subtrahend) |
| size_i | input | 2 | Width code: 00 byte, 01 word, 10 long, 11 illegal |
| addr_mode_i | input | 1 | Address-compare mode |
| ccr_o | output | 5 | Flag register {X, N, Z, V, C} |
| err_o | output | 1 | Illegal-size pulse |

## Verification
Each width is driven with operands that produce each flag on its own: equal values for Z, a small value minus a larger one for N and C, and the values around the signed limits for V. The byte and word vectors put junk in the upper bits on purpose, which shows that only the low lanes matter. Some address-mode word vectors would give a different answer without sign extension: an all-ones low half against a zero-extended destination, and a destination that differs from the source only above bit 15. Illegal codes, idle cycles with changing inputs, and a reset taken mid-stream show that the register holds or clears as required.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_BAD  = 2'b11
  } cmp_size_e;

  typedef struct packed {
    logic x;
    logic n;
    logic z;
    logic v;
    logic c;
  } ccr_t;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = 16;
endpackage

// File: rtl/cmp_operand_prep.sv
module cmp_operand_prep
  import cmp_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [1:0]        size_i,
  input  logic              addr_mode_i,
  output logic [DATA_W-1:0] dst_j,
  output logic [DATA_W-1:0] src_j,
  output logic              illegal_o
);
  // Operands are placed so that the selected width ends at the MSB.
  // One full-width subtractor then yields correct flags for every size.
  localparam int unsigned BYTE_SH = DATA_W - BYTE_W;
  localparam int unsigned WORD_SH = DATA_W - WORD_W;

  logic [DATA_W-1:0] src_sext;
  assign src_sext = {{(DATA_W-WORD_W){src_i[WORD_W-1]}}, src_i[WORD_W-1:0]};

  always_comb begin
    dst_j     = dst_i;
    src_j     = src_i;
    illegal_o = 1'b0;
    if (addr_mode_i) begin
      unique case (cmp_size_e'(size_i))
        SZ_WORD: src_j = src_sext;
        SZ_LONG: ;
        default: illegal_o = 1'b1;
      endcase
    end else begin
      unique case (cmp_size_e'(size_i))
        SZ_BYTE: begin
          dst_j = dst_i << BYTE_SH;
          src_j = src_i << BYTE_SH;
        end
        SZ_WORD: begin
          dst_j = dst_i << WORD_SH;
          src_j = src_i << WORD_SH;
        end
        SZ_LONG: ;
        default: illegal_o = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/cmp_flag_calc.sv
module cmp_flag_calc #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         n_o,
  output logic         z_o,
  output logic         v_o,
  output logic         c_o
);
  logic [W:0] diff;
  assign diff = {1'b0, a_i} - {1'b0, b_i};

  assign c_o = diff[W];
  assign n_o = diff[W-1];
  assign z_o = (diff[W-1:0] == '0);
  assign v_o = (a_i[W-1] ^ b_i[W-1]) & (diff[W-1] ^ a_i[W-1]);
endmodule

// File: rtl/cmp_flag_unit.sv
module cmp_flag_unit
  import cmp_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [1:0]        size_i,
  input  logic              addr_mode_i,
  output logic [4:0]        ccr_o,
  output logic              err_o
);
  logic [DATA_W-1:0] dst_j, src_j;
  logic              illegal;
  logic              n, z, v, c;
  ccr_t              ccr_q;

  cmp_operand_prep #(.DATA_W(DATA_W)) u_prep (
    .dst_i       (dst_i),
    .src_i       (src_i),
    .size_i      (size_i),
    .addr_mode_i (addr_mode_i),
    .dst_j       (dst_j),
    .src_j       (src_j),
    .illegal_o   (illegal)
  );

  cmp_flag_calc #(.W(DATA_W)) u_calc (
    .a_i (dst_j),
    .b_i (src_j),
    .n_o (n),
    .z_o (z),
    .v_o (v),
    .c_o (c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ccr_q <= '0;
      err_o <= 1'b0;
    end else begin
      err_o <= valid_i & illegal;
      if (valid_i && !illegal) begin
        ccr_q.n <= n;
        ccr_q.z <= z;
        ccr_q.v <= v;
        ccr_q.c <= c;
      end
    end
  end

  assign ccr_o = ccr_q;
endmodule

// File: rtl/cmp_flag_unit_chk.sv
module cmp_flag_unit_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              valid_i,
  input logic [DATA_W-1:0] dst_i,
  input logic [DATA_W-1:0] src_i,
  input logic [1:0]        size_i,
  input logic              addr_mode_i,
  input logic [4:0]        ccr_o,
  input logic              err_o
);
  logic bad_size;
  assign bad_size = (size_i == 2'b11) || (addr_mode_i && size_i == 2'b00);

  p_reset_clear_r11: assert property (@(posedge clk)
    rst |=> (ccr_o == 5'd0) && !err_o);

  p_x_untouched_r8: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> ccr_o[4] == $past(ccr_o[4]));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> $stable(ccr_o) && !err_o);

  p_illegal_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (valid_i && bad_size) |=> err_o && $stable(ccr_o));

  p_legal_no_err_r10: assert property (@(posedge clk) disable iff (rst)
    (valid_i && !bad_size) |=> !err_o);

  p_long_zero_r1: assert property (@(posedge clk) disable iff (rst)
    (valid_i && size_i == 2'b10) |=> ccr_o[2] == ($past(dst_i) == $past(src_i)));

  p_long_borrow_r5: assert property (@(posedge clk) disable iff (rst)
    (valid_i && size_i == 2'b10) |=> ccr_o[0] == ($past(src_i) > $past(dst_i)));
endmodule

bind cmp_flag_unit cmp_flag_unit_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/cmp_flag_unit_bench.sv
module cmp_flag_unit_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        valid_i;
  logic [31:0] dst_i, src_i;
  logic [1:0]  size_i;
  logic        addr_mode_i;
  logic [4:0]  ccr_o;
  logic        err_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  cmp_flag_unit u_cmp_flag_unit (
    .clk(clk), .rst(rst), .valid_i(valid_i), .dst_i(dst_i), .src_i(src_i),
    .size_i(size_i), .addr_mode_i(addr_mode_i), .ccr_o(ccr_o), .err_o(err_o)
  );

  // {addr, size, dst, src, expected NZVC, expected err}
  localparam int NV = 16;
  localparam logic [71:0] VEC [NV] = '{
    {1'b0, 2'b10, 32'h0000_0005, 32'h0000_0003, 4'b0000, 1'b0}, // R1
    {1'b0, 2'b10, 32'h0000_0003, 32'h0000_0005, 4'b1001, 1'b0}, // R5
    {1'b0, 2'b10, 32'h1234_5678, 32'h1234_5678, 4'b0100, 1'b0}, // R1
    {1'b0, 2'b10, 32'h8000_0000, 32'h0000_0001, 4'b0010, 1'b0}, // R4
    {1'b0, 2'b10, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'b1011, 1'b0}, // R4
    {1'b0, 2'b00, 32'hAAAA_AA10, 32'h5555_5510, 4'b0100, 1'b0}, // R2
    {1'b0, 2'b00, 32'h0000_0080, 32'h0000_0001, 4'b0010, 1'b0}, // R2
    {1'b0, 2'b00, 32'h0000_0000, 32'hFFFF_FF01, 4'b1001, 1'b0}, // R2
    {1'b0, 2'b01, 32'hFFFF_0003, 32'h0000_0004, 4'b1001, 1'b0}, // R3
    {1'b0, 2'b01, 32'h1234_8000, 32'h0000_0001, 4'b0010, 1'b0}, // R3
    {1'b1, 2'b01, 32'hFFFF_FFFF, 32'h0000_FFFF, 4'b0100, 1'b0}, // R6
    {1'b1, 2'b01, 32'h0000_FFFF, 32'h0000_FFFF, 4'b0001, 1'b0}, // R6
    {1'b1, 2'b01, 32'h0001_0000, 32'h0000_0000, 4'b0000, 1'b0}, // R6
    {1'b1, 2'b10, 32'h0000_0010, 32'h0000_0020, 4'b1001, 1'b0}, // R7
    {1'b0, 2'b11, 32'h0000_0001, 32'h0000_0001, 4'b1001, 1'b1}, // R10
    {1'b1, 2'b00, 32'h0000_0001, 32'h0000_0001, 4'b1001, 1'b1}  // R10
  };

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {ccr,err} actual %b expected %b", req, act, exp);
    end
  endtask

  function automatic string tag_of(input int i);
    case (i)
      0, 2: return "R1";
      1: return "R5";
      3, 4: return "R4";
      5, 6, 7: return "R2";
      8, 9: return "R3";
      10, 11, 12: return "R6";
      13: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #20000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; valid_i = 1'b0; dst_i = '0; src_i = '0;
    size_i = 2'b10; addr_mode_i = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R11 reset", {ccr_o, err_o}, 6'b0);

    for (int i = 0; i < NV; i++) begin
      {addr_mode_i, size_i, dst_i, src_i} = VEC[i][71:5];
      valid_i = 1'b1;
      @(negedge clk);
      valid_i = 1'b0;
      check(tag_of(i), {ccr_o, err_o}, {1'b0, VEC[i][4:0]});
      check("R8 x bit", {5'b0, ccr_o[4]}, 6'b0);
    end

    // R9: inputs change while idle; register holds 1001 from last legal compare
    dst_i = 32'h0; src_i = 32'h0; size_i = 2'b10; addr_mode_i = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 idle hold", {ccr_o, err_o}, 6'b010010);

    // R9: single valid loads, result visible next cycle
    dst_i = 32'h0000_0042; src_i = 32'h0000_0042;
    valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    dst_i = 32'h0; src_i = 32'h1;
    check("R9 load", {ccr_o, err_o}, 6'b001000);
    @(negedge clk);
    check("R10 err low after", {5'b0, err_o}, 6'b0);

    // R11: mid-run reset after nonzero flags
    dst_i = 32'h1; src_i = 32'h2; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    check("R5 pre-reset", {ccr_o, err_o}, 6'b010010);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R11 mid reset", {ccr_o, err_o}, 6'b0);

    finish_run();
  end
endmodule